// File: doc/BRIEF.md
# Rate-Scaled Envelope Generator for a Wavetable Voice

This block shapes the loudness of one sample-playback voice over time. It holds a 10-bit attenuation, where 0 is full level and 511 is silence, and steps through the phases attack, first decay, sustain, release, pseudo-reverb and damp. When no note is sounding it sits in an idle phase. A chip-wide envelope counter paces the block. On each cycle where `eg_tick` is high, the block reads the counter value and decides whether its current rate allows an update on that count, and by how much.

Each phase has a 4-bit register rate. The block turns it into a 6-bit effective rate, which depends on a rate-correction field, the signed octave and the top bit of the frequency number. The effective rate sets the spacing of updates and selects an increment pattern. The attack phase moves exponentially toward 0. All other phases add a fixed increment toward 511.

Key-on, key-off and damp are one-cycle command pulses. The outputs are the attenuation and a flag that is high while the voice is sounding.

Top module: `pcm_env_gen`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `att_o` is 511 and `voice_active` is 0.
- R2: The effective rate is computed as follows. A register rate of 0 gives 0, and 15 gives 63. When `rate_corr` is 15, the result is register rate × 4. Otherwise the result is (signed `octave`, two's complement −8..7, + `rate_corr`) × 2 + `fnum_hi` + register rate × 4, clamped to 0..63.
- R3: While the effective rate is below 4, the attenuation holds its value. This applies in attack, first decay, sustain and release, but not in pseudo-reverb or damp.
- R4: Updates depend on a shift value, which is 12 − rate/4 (floored at 0). An update happens only on a tick whose counter has all of its low `shift` bits at zero. The increment is chosen by index i = (counter >> shift) & 7:
  - Rates below 52 add 1. The condition depends on rate mod 4: when i is odd (mod 0); when i is odd or i = 4 (mod 1); when i mod 4 ≠ 0 (mod 2); when i ≠ 0 (mod 3).
  - Rates 52..55 add 1, or 2 when: never (mod 0); i mod 4 = 3 (mod 1); i is odd (mod 2); i mod 4 ≠ 0 (mod 3).
  - Rates 56..59 use twice the 52..55 values.
  - Rates 60..63 add 4, or 8 in attack.
- R5: Attack sets att ← att + floor(−(att+1)·inc / 8). When the result is ≤ 0, the attenuation becomes 0. The phase then goes to first decay if `dl_idx` ≠ 0, and to sustain otherwise.
- R6: The decay level is `dl_idx` × 16, except that index 15 gives 496. First decay moves to sustain once the attenuation is ≥ that level.
- R7: Sustain and release add their increment. On reaching 511 or more, the attenuation clamps to 511, the voice goes idle and `voice_active` drops.
- R8: With `reverb_en` set, first decay, sustain and release switch to pseudo-reverb once the attenuation exceeds 96. Pseudo-reverb uses register rate 5 through the R2 formula and clamps at 511 into idle.
- R9: A damp pulse always enters damp, at effective rate 56. Damp clamps at 511 into idle.
- R10: Key-off moves a sounding voice to release, unless it is in pseudo-reverb. When the voice is idle or in pseudo-reverb, key-off has no effect.
- R11: Key-on enters attack. It first loads 511 when the voice is idle; a sounding voice keeps its attenuation. Damp outranks key-on, and key-on outranks key-off.
- R12: Attenuation changes only in the cycle after a tick or a command. A command in the same cycle as a tick overrides the tick's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eg_tick | input | 1 | Envelope counter advanced this cycle |
| eg_cnt | input | CNT_W | Global envelope counter value |
| ar_rate | input | 4 | Attack register rate |
| dec1_rate | input | 4 | First-decay register rate |
| dec2_rate | input | 4 | Sustain-phase register rate |
| rel_rate | input | 4 | Release register rate |
| dl_idx | input | 4 | Decay level index |
| rate_corr | input | 4 | Rate correction |
| octave | input | 4 | Signed octave |
| fnum_hi | input | 1 | Frequency number bit 9 |
| reverb_en | input | 1 | Pseudo-reverb enable |
| key_on | input | 1 | Key-on pulse |
| key_off | input | 1 | Key-off pulse |
| damp | input | 1 | Damp pulse |
| att_o | output | 10 | Attenuation, 0 loud, 511 silent |
| voice_active | output | 1 | Voice sounding |

## Verification
The attack is driven at rate 52, where a single increment per tick exposes the exponential curve and its floor rounding. It is also driven at rate 60, where the attack-only increment of 8 must finish in one tick, and at rate 56, which would not finish.

Three further settings separate the rate arithmetic:
- A clamped-negative rate must freeze the envelope, while the same register rate with correction 15 must move it.
- An odd/even counter sweep at rate 44 confirms the gating on the low counter bits.
- A sweep at rate 47 confirms both the octave and frequency-bit terms and the pattern row.

Long release runs check the exact clamp cycle. A pseudo-reverb run checks the 96 threshold, the slower reverb rate and the fact that key-off is ignored there. Damp and command collisions show that commands take priority over ticks.

// File: rtl/eg_pkg.sv
package eg_pkg;
  typedef enum logic [2:0] {
    EG_IDLE = 3'd0,
    EG_ATK  = 3'd1,
    EG_DEC  = 3'd2,
    EG_SUS  = 3'd3,
    EG_REL  = 3'd4,
    EG_REV  = 3'd5,
    EG_DMP  = 3'd6
  } eg_state_e;

  localparam int ENV_W        = 10;
  localparam int RATE_W       = 6;
  localparam int INC_W        = 4;
  localparam int ENV_SILENT   = 511;
  localparam int REV_KNEE     = 96;
  localparam int DAMP_RATE    = 56;
  localparam int REV_REG_RATE = 5;
  localparam int FREEZE_BELOW = 4;
endpackage

// File: rtl/eg_rate_calc.sv
module eg_rate_calc
  import eg_pkg::*;
(
  input  logic [3:0]        reg_rate,
  input  logic [3:0]        rate_corr,
  input  logic [3:0]        octave,
  input  logic              fnum_hi,
  output logic [RATE_W-1:0] eff_rate
);
  logic signed [7:0] oct_s, rc_s, base_s, sum_s;

  always_comb begin
    oct_s  = {{4{octave[3]}}, octave};
    rc_s   = $signed({4'b0000, rate_corr});
    base_s = oct_s + rc_s;
    sum_s  = base_s + base_s + $signed({7'd0, fnum_hi})
           + $signed({2'b00, reg_rate, 2'b00});
    if (reg_rate == 4'd0)        eff_rate = '0;
    else if (reg_rate == 4'd15)  eff_rate = 6'd63;
    else if (rate_corr == 4'd15) eff_rate = {reg_rate, 2'b00};
    else if (sum_s < 0)          eff_rate = '0;
    else if (sum_s > 8'sd63)     eff_rate = 6'd63;
    else                         eff_rate = sum_s[5:0];
  end
endmodule

// File: rtl/eg_step_gen.sv
module eg_step_gen
  import eg_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic [CNT_W-1:0]  cnt,
  input  logic [RATE_W-1:0] rate,
  input  logic              attack,
  output logic              fire,
  output logic [INC_W-1:0]  inc
);
  logic [3:0]       shift;
  logic [CNT_W-1:0] mask;
  logic [2:0]       idx;
  logic [1:0]       lo;
  logic             frac;
  logic             two;

  always_comb begin
    shift = (rate[5:2] >= 4'd12) ? 4'd0 : (4'd12 - rate[5:2]);
    mask  = (CNT_W'(1) << shift) - CNT_W'(1);
    fire  = ((cnt & mask) == '0);
    idx   = 3'(cnt >> shift);
    lo    = rate[1:0];
    case (lo)
      2'd0:    frac = idx[0];
      2'd1:    frac = idx[0] | (idx == 3'd4);
      2'd2:    frac = (idx[1:0] != 2'd0);
      default: frac = (idx != 3'd0);
    endcase
    case (lo)
      2'd0:    two = 1'b0;
      2'd1:    two = (idx[1:0] == 2'd3);
      2'd2:    two = idx[0];
      default: two = (idx[1:0] != 2'd0);
    endcase
    if (rate >= 6'd60)      inc = attack ? 4'd8 : 4'd4;
    else if (rate >= 6'd56) inc = two ? 4'd4 : 4'd2;
    else if (rate >= 6'd52) inc = two ? 4'd2 : 4'd1;
    else                    inc = {3'b000, frac};
  end
endmodule

// File: rtl/pcm_env_gen.sv
module pcm_env_gen
  import eg_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eg_tick,
  input  logic [CNT_W-1:0] eg_cnt,
  input  logic [3:0]       ar_rate,
  input  logic [3:0]       dec1_rate,
  input  logic [3:0]       dec2_rate,
  input  logic [3:0]       rel_rate,
  input  logic [3:0]       dl_idx,
  input  logic [3:0]       rate_corr,
  input  logic [3:0]       octave,
  input  logic             fnum_hi,
  input  logic             reverb_en,
  input  logic             key_on,
  input  logic             key_off,
  input  logic             damp,
  output logic [9:0]       att_o,
  output logic             voice_active
);
  localparam logic [ENV_W-1:0]  SILENT = ENV_W'(ENV_SILENT);
  localparam logic [ENV_W:0]    SILENT_X = (ENV_W+1)'(ENV_SILENT);
  localparam logic [ENV_W:0]    KNEE   = (ENV_W+1)'(REV_KNEE);
  localparam logic [RATE_W-1:0] DMP_R  = RATE_W'(DAMP_RATE);

  eg_state_e         state_q, state_n;
  logic [ENV_W-1:0]  env_q, env_n;
  logic [3:0]        sel_rate;
  logic [RATE_W-1:0] calc_rate, eff_rate;
  logic              fire, frozen;
  logic [INC_W-1:0]  inc;
  logic [ENV_W:0]    add_sum, dl_lvl;
  logic [ENV_W-1:0]  add_sat;
  logic signed [15:0] atk_prod, atk_sum;

  always_comb begin
    case (state_q)
      EG_ATK:  sel_rate = ar_rate;
      EG_DEC:  sel_rate = dec1_rate;
      EG_SUS:  sel_rate = dec2_rate;
      EG_REL:  sel_rate = rel_rate;
      EG_REV:  sel_rate = 4'(REV_REG_RATE);
      default: sel_rate = 4'd0;
    endcase
  end

  eg_rate_calc u_rate (
    .reg_rate (sel_rate),
    .rate_corr(rate_corr),
    .octave   (octave),
    .fnum_hi  (fnum_hi),
    .eff_rate (calc_rate)
  );

  assign eff_rate = (state_q == EG_DMP) ? DMP_R : calc_rate;
  assign frozen   = (eff_rate < RATE_W'(FREEZE_BELOW))
                  && (state_q != EG_REV) && (state_q != EG_DMP);

  eg_step_gen #(.CNT_W(CNT_W)) u_step (
    .cnt   (eg_cnt),
    .rate  (eff_rate),
    .attack(state_q == EG_ATK),
    .fire  (fire),
    .inc   (inc)
  );

  always_comb begin
    dl_lvl   = {1'b0, (dl_idx == 4'd15) ? 5'd31 : {1'b0, dl_idx}, 4'b0000};
    add_sum  = {1'b0, env_q} + (ENV_W+1)'(inc);
    add_sat  = (add_sum > SILENT_X) ? SILENT : add_sum[ENV_W-1:0];
    atk_prod = -($signed({6'd0, env_q}) + 16'sd1) * $signed({12'd0, inc});
    atk_sum  = $signed({6'd0, env_q}) + (atk_prod >>> 3);
  end

  always_comb begin
    state_n = state_q;
    env_n   = env_q;
    if (damp) begin
      state_n = EG_DMP;
    end else if (key_on) begin
      state_n = EG_ATK;
      if (state_q == EG_IDLE) env_n = SILENT;
    end else if (key_off) begin
      if (state_q != EG_IDLE && state_q != EG_REV) state_n = EG_REL;
    end else if (eg_tick && fire && !frozen) begin
      case (state_q)
        EG_ATK: begin
          if (atk_sum <= 16'sd0) begin
            env_n   = '0;
            state_n = (dl_idx != 4'd0) ? EG_DEC : EG_SUS;
          end else begin
            env_n = atk_sum[ENV_W-1:0];
          end
        end
        EG_DEC: begin
          env_n = add_sat;
          if (reverb_en && add_sum > KNEE) state_n = EG_REV;
          else if (add_sum >= dl_lvl)      state_n = EG_SUS;
        end
        EG_SUS, EG_REL: begin
          env_n = add_sat;
          if (reverb_en && add_sum > KNEE) state_n = EG_REV;
          else if (add_sum >= SILENT_X)    state_n = EG_IDLE;
        end
        EG_REV, EG_DMP: begin
          env_n = add_sat;
          if (add_sum >= SILENT_X) state_n = EG_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= EG_IDLE;
      env_q   <= SILENT;
    end else begin
      state_q <= state_n;
      env_q   <= env_n;
    end
  end

  assign att_o        = env_q;
  assign voice_active = (state_q != EG_IDLE);
endmodule

// File: rtl/pcm_env_gen_chk.sv
module pcm_env_gen_chk
  import eg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       eg_tick,
  input logic       key_on,
  input logic       key_off,
  input logic       damp,
  input logic [9:0] att,
  input logic       active,
  input eg_state_e  st
);
  a_r7_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> att == 10'd511);

  a_r12_hold_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!eg_tick && !key_on && !key_off && !damp) |=> $stable(att));

  a_r4_bounded_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (st != EG_ATK && !key_on) |=> (att >= $past(att)) && (att <= $past(att) + 10'd8));

  a_r5_attack_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EG_ATK && !key_on && !key_off && !damp) |=> att <= $past(att));

  a_r10_reverb_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EG_REV && !damp && !key_on) |=> (st == EG_REV || st == EG_IDLE));

  a_r11_keyon_attack: assert property (@(posedge clk) disable iff (!rst_n)
    (key_on && !damp) |=> st == EG_ATK);

  a_r9_damp_enter: assert property (@(posedge clk) disable iff (!rst_n)
    damp |=> st == EG_DMP);
endmodule

bind pcm_env_gen pcm_env_gen_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .eg_tick(eg_tick),
  .key_on (key_on),
  .key_off(key_off),
  .damp   (damp),
  .att    (att_o),
  .active (voice_active),
  .st     (state_q)
);

// File: tb/pcm_env_gen_tb.sv
module pcm_env_gen_tb;
  localparam int CNT_W = 18;

  logic clk = 0, rst_n = 0, eg_tick = 0, fnum_hi = 0, reverb_en = 0;
  logic key_on = 0, key_off = 0, damp = 0;
  logic [CNT_W-1:0] eg_cnt = '0;
  logic [3:0] ar_rate = 0, dec1_rate = 0, dec2_rate = 0, rel_rate = 0;
  logic [3:0] dl_idx = 0, rate_corr = 0, octave = 0;
  logic [9:0] att_o;
  logic voice_active;
  int n_chk = 0, n_fail = 0, cyc_cnt = 0;

  always #4 clk = ~clk;

  pcm_env_gen #(.CNT_W(CNT_W)) u_dut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic tk, input int cnt, input logic kon, input logic koff, input logic dmp);
    @(negedge clk);
    eg_tick = tk; eg_cnt = CNT_W'(cnt); key_on = kon; key_off = koff; damp = dmp;
    @(negedge clk);
    eg_tick = 0; key_on = 0; key_off = 0; damp = 0;
  endtask

  task automatic ticks(input int n, input int cnt);
    for (int i = 0; i < n; i++) cyc(1, cnt, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  // reaches sustain at attenuation 16 (fast attack, fast decay to level 16)
  task automatic to_sustain16(input logic rev);
    do_reset();
    rate_corr = 15; octave = 0; fnum_hi = 0; reverb_en = rev;
    ar_rate = 15; dec1_rate = 15; dl_idx = 1; dec2_rate = 0; rel_rate = 15;
    cyc(0, 0, 1, 0, 0);
    ticks(1, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 att", int'(att_o), 511);
    check("R1 active", int'(voice_active), 0);
    cyc(0, 0, 0, 1, 0);
    ticks(1, 0);
    check("R10 keyoff idle att", int'(att_o), 511);
    check("R10 keyoff idle active", int'(voice_active), 0);
    cyc(0, 0, 0, 0, 1);
    check("R9 damp from idle active", int'(voice_active), 1);
    ticks(1, 0);
    check("R9 damp clamps to idle", int'(voice_active), 0);
  endtask

  task automatic t_rate_clamp();
    do_reset();
    rate_corr = 0; octave = 4'b1000; fnum_hi = 0; ar_rate = 1; dl_idx = 0;
    cyc(0, 0, 1, 0, 0);
    ticks(1, 2048);
    check("R3 frozen rate att", int'(att_o), 511);
    check("R11 keyon active", int'(voice_active), 1);
    do_reset();
    rate_corr = 15;
    cyc(0, 0, 1, 0, 0);
    ticks(1, 2048);
    check("R2 rc15 rate4 attack", int'(att_o), 447);
  endtask

  task automatic t_attack_exp();
    do_reset();
    rate_corr = 15; octave = 0; ar_rate = 13; dl_idx = 0; dec2_rate = 0;
    cyc(0, 0, 1, 0, 0);
    ticks(1, 0);
    check("R5 attack step1", int'(att_o), 447);
    ticks(3, 0);
    check("R5 attack floor", int'(att_o), 299);
    ticks(200, 0);
    check("R5 attack reaches 0", int'(att_o), 0);
  endtask

  task automatic t_rate_sixty();
    do_reset();
    rate_corr = 14; octave = 0; fnum_hi = 0; ar_rate = 8; dl_idx = 0;
    cyc(0, 0, 1, 0, 0);
    ticks(1, 0);
    check("R4 rate60 attack one tick", int'(att_o), 0);
    do_reset();
    rate_corr = 15; ar_rate = 14;
    cyc(0, 0, 1, 0, 0);
    ticks(1, 0);
    check("R4 rate56 attack", int'(att_o), 383);
  endtask

  task automatic t_decay_level();
    to_sustain16(0);
    ticks(3, 0);
    check("R6 decay mid", int'(att_o), 12);
    ticks(3, 0);
    check("R6 stops at level 16", int'(att_o), 16);
  endtask

  task automatic t_shift_gate();
    do_reset();
    rate_corr = 15; ar_rate = 15; dl_idx = 15; dec1_rate = 11;
    cyc(0, 0, 1, 0, 0);
    ticks(1, 0);
    ticks(1, 1);
    check("R4 odd count skipped", int'(att_o), 0);
    for (int c = 2; c <= 8; c++) ticks(1, c);
    check("R4 rate44 pattern", int'(att_o), 2);
  endtask

  task automatic t_rate_scale();
    do_reset();
    rate_corr = 14; octave = 7; fnum_hi = 1; ar_rate = 15; dl_idx = 15; dec1_rate = 1;
    cyc(0, 0, 1, 0, 0);
    ticks(1, 0);
    for (int c = 2; c <= 16; c += 2) ticks(1, c);
    check("R2 rate47 scaled", int'(att_o), 7);
  endtask

  task automatic t_release();
    to_sustain16(0);
    ticks(4, 0);
    cyc(0, 0, 0, 1, 0);
    ticks(123, 0);
    check("R7 release 508", int'(att_o), 508);
    check("R7 still active", int'(voice_active), 1);
    ticks(1, 0);
    check("R7 clamp 511", int'(att_o), 511);
    check("R7 inactive", int'(voice_active), 0);
  endtask

  task automatic t_reverb();
    to_sustain16(1);
    ticks(4, 0);
    cyc(0, 0, 0, 1, 0);
    ticks(20, 0);
    check("R8 at knee", int'(att_o), 96);
    ticks(1, 0);
    check("R8 past knee", int'(att_o), 100);
    cyc(0, 0, 0, 1, 0);
    ticks(1, 1);
    check("R10 keyoff ignored in reverb", int'(att_o), 100);
    ticks(1, 128);
    check("R8 reverb rate20", int'(att_o), 101);
  endtask

  task automatic t_damp();
    to_sustain16(0);
    ticks(4, 0);
    cyc(1, 0, 0, 0, 1);
    check("R12 damp beats tick", int'(att_o), 16);
    ticks(10, 0);
    check("R9 damp rate56", int'(att_o), 36);
    ar_rate = 0;
    cyc(0, 0, 1, 0, 0);
    ticks(3, 0);
    check("R11 retrigger keeps level", int'(att_o), 36);
    check("R11 retrigger active", int'(voice_active), 1);
    cyc(0, 0, 0, 1, 0);
    ticks(1, 0);
    check("R10 keyoff to release", int'(att_o), 40);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_rate_clamp();
    t_attack_exp();
    t_rate_sixty();
    t_decay_level();
    t_shift_gate();
    t_rate_scale();
    t_release();
    t_reverb();
    t_damp();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule